// File: doc/BRIEF.md
# Paired Round-Robin Shared-Memory Slot Arbiter

This block decides, one cycle at a time, which of a set of processor cores may use a single-ported shared memory. A slot counter steps through the core indices. The core whose index matches the counter owns that slot. Cores form fixed pairs: a core and the core whose index differs only in the most significant bit. When the owner has no shared-memory operation about to run, its partner may take the slot instead. Each core therefore keeps its own slot every rotation, and it can get up to twice that share by using slots its partner leaves idle. Cores outside the pair are never affected.

Each core provides three level signals. The first says the core is running. The second says the core was launched to use shared memory. The third is a pipeline flag saying that the instruction about to execute is a shared-memory access. A two-bit scan mode sets how the counter advances:
- It can visit every index.
- It can wrap early after a configured top index, which is latched only at a wrap.
- It can visit only cores that are running with shared-memory use enabled, in ascending order.

The grant is registered. It is presented as a one-hot vector together with the index of the granted core.

Top module: `hub_pair_arbiter`

## Requirements
- R1: While reset is high, at the first rising edge the grant vector and the index output go to zero. The slot counter returns to 0 and the latched top index is set to the highest core index. After reset is released, the first slot decided is slot 0.
- R2: A core is eligible when its running, hub-enable and next-is-hub inputs are all high. If the owner of the current slot s is eligible, the owner alone is granted, with index s.
- R3: If the owner of slot s is not eligible and its partner (s with the index MSB inverted; core N pairs with N+8 for 16 cores) is eligible, the partner alone is granted, with that partner's index.
- R4: If neither pair member is eligible, no grant bit is set and the index output is 0.
- R5: At most one grant bit is high in any cycle. When one is high, the index output equals its bit position.
- R6: In scan mode 0 (code 3 behaves the same), the counter advances by one each cycle and wraps from the highest core index to 0.
- R7: In scan mode 1, the counter wraps to 0 in the cycle after it has reached or passed the latched top index, and otherwise advances by one. The latched top index takes the top-index input only on a cycle where the counter wraps.
- R8: In scan mode 2, the counter moves to the next higher core that is both running and hub-enabled. If there is none, it moves to the lowest such core. If no core qualifies, the counter goes to 0. The top index is also latched here whenever the new counter value is not greater than the old one.
- R9: The grant and index outputs change only at a rising clock edge. They reflect the inputs and slot of the cycle before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| scan_mode_i | input | 2 | Counter mode: 0 full, 1 early wrap at top, 2 active cores only, 3 full |
| top_core_i | input | 4 | Highest core index used in early-wrap mode |
| run_i | input | 16 | Per-core running flag |
| hub_en_i | input | 16 | Per-core shared-memory use enabled at launch |
| want_i | input | 16 | Per-core flag: next instruction is a shared-memory access |
| grant_o | output | 16 | Registered one-hot grant, or all zero |
| idx_o | output | 4 | Index of the granted core, 0 when no grant |

## Verification
Two events often happen in the same cycle: a change in the lending decision for a pair, and the counter wrapping and picking up a new top index. The stimulus provokes both at once. It moves the top-index input while the counter is partway through a rotation in early-wrap mode, and it reshapes the running and hub-enable sets while active-only scanning is under way. Throughout, the next-is-hub flags of both pair members are randomised. An independent model in the bench tracks the counter and the latched top index from the rules above. Every cycle, the grant vector and the index are compared against that model, so a misplaced wrap and a wrong lending choice are caught separately.

// File: rtl/hub_arb_pkg.sv
package hub_arb_pkg;
    typedef enum logic [1:0] {
        SCAN_FULL   = 2'd0,
        SCAN_TOP    = 2'd1,
        SCAN_ACTIVE = 2'd2,
        SCAN_FULL_B = 2'd3
    } scan_mode_t;
endpackage

// File: rtl/hub_slot_seq.sv
module hub_slot_seq
    import hub_arb_pkg::*;
#(
    parameter int NUM_CORES = 16,
    localparam int IDX_W = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  scan_mode_t           mode,
    input  logic [IDX_W-1:0]     top_in,
    input  logic [NUM_CORES-1:0] participate,
    output logic [IDX_W-1:0]     slot_q
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

    logic [IDX_W-1:0] top_q;
    logic [IDX_W-1:0] slot_nxt;
    logic [IDX_W-1:0] above_idx;
    logic [IDX_W-1:0] lowest_idx;
    logic             above_found;
    logic             any_found;
    logic             wrap;

    // search for the next participating core above the slot, and the lowest overall
    always_comb begin
        above_idx   = '0;
        lowest_idx  = '0;
        above_found = 1'b0;
        any_found   = 1'b0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (participate[i]) begin
                lowest_idx = IDX_W'(i);
                any_found  = 1'b1;
                if (IDX_W'(i) > slot_q) begin
                    above_idx   = IDX_W'(i);
                    above_found = 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (mode)
            SCAN_TOP:
                slot_nxt = (slot_q >= top_q) ? '0 : slot_q + 1'b1;
            SCAN_ACTIVE:
                slot_nxt = above_found ? above_idx : (any_found ? lowest_idx : '0);
            SCAN_FULL, SCAN_FULL_B:
                slot_nxt = (slot_q == LAST_IDX) ? '0 : slot_q + 1'b1;
            default:
                slot_nxt = '0;
        endcase
    end

    assign wrap = (slot_nxt <= slot_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            top_q  <= LAST_IDX;
        end else begin
            slot_q <= slot_nxt;
            if (wrap) begin
                top_q <= top_in;
            end
        end
    end
endmodule

// File: rtl/hub_pair_pick.sv
module hub_pair_pick #(
    parameter int NUM_CORES = 16,
    localparam int IDX_W = $clog2(NUM_CORES)
) (
    input  logic [IDX_W-1:0]     slot,
    input  logic [NUM_CORES-1:0] eligible,
    output logic                 pick_valid,
    output logic [IDX_W-1:0]     pick_idx
);
    localparam logic [IDX_W-1:0] PAIR_FLIP = {1'b1, {(IDX_W-1){1'b0}}};

    logic [IDX_W-1:0] partner;

    assign partner = slot ^ PAIR_FLIP;

    always_comb begin
        pick_valid = 1'b0;
        pick_idx   = '0;
        if (eligible[slot]) begin
            pick_valid = 1'b1;
            pick_idx   = slot;
        end else if (eligible[partner]) begin
            pick_valid = 1'b1;
            pick_idx   = partner;
        end
    end
endmodule

// File: rtl/hub_pair_arbiter.sv
module hub_pair_arbiter
    import hub_arb_pkg::*;
#(
    parameter int NUM_CORES = 16,
    localparam int IDX_W = $clog2(NUM_CORES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           scan_mode_i,
    input  logic [IDX_W-1:0]     top_core_i,
    input  logic [NUM_CORES-1:0] run_i,
    input  logic [NUM_CORES-1:0] hub_en_i,
    input  logic [NUM_CORES-1:0] want_i,
    output logic [NUM_CORES-1:0] grant_o,
    output logic [IDX_W-1:0]     idx_o
);
    logic [IDX_W-1:0]     slot_q;
    logic [NUM_CORES-1:0] participate;
    logic [NUM_CORES-1:0] eligible;
    logic                 pick_valid;
    logic [IDX_W-1:0]     pick_idx;
    scan_mode_t           mode;

    assign mode        = scan_mode_t'(scan_mode_i);
    assign participate = run_i & hub_en_i;
    assign eligible    = participate & want_i;

    hub_slot_seq #(.NUM_CORES(NUM_CORES)) seq_i (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .top_in      (top_core_i),
        .participate (participate),
        .slot_q      (slot_q)
    );

    hub_pair_pick #(.NUM_CORES(NUM_CORES)) pick_i (
        .slot       (slot_q),
        .eligible   (eligible),
        .pick_valid (pick_valid),
        .pick_idx   (pick_idx)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst) begin
            grant_o <= '0;
            idx_o   <= '0;
        end else begin
            grant_o <= pick_valid ? (NUM_CORES'(1) << pick_idx) : '0;
            idx_o   <= pick_valid ? pick_idx : '0;
        end
    end
endmodule

// File: rtl/hub_pair_arbiter_chk.sv
module hub_pair_arbiter_chk #(
    parameter int NUM_CORES = 16,
    localparam int IDX_W = $clog2(NUM_CORES)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_CORES-1:0] grant,
    input logic [IDX_W-1:0]     idx,
    input logic [IDX_W-1:0]     slot,
    input logic [NUM_CORES-1:0] elig
);
    localparam logic [IDX_W-1:0]     FLIP = {1'b1, {(IDX_W-1){1'b0}}};
    localparam logic [NUM_CORES-1:0] ONE  = NUM_CORES'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (grant == '0 && idx == '0 && slot == '0));

    // R5
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R5
    idx_match_chk: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> grant[idx]);

    // R4
    idle_idx_chk: assert property (@(posedge clk) disable iff (rst)
        (grant == '0) |-> (idx == '0));

    // R2
    owner_first_chk: assert property (@(posedge clk) disable iff (rst)
        elig[slot] |=> (grant == (ONE << $past(slot))));

    // R3
    partner_lend_chk: assert property (@(posedge clk) disable iff (rst)
        (!elig[slot] && elig[slot ^ FLIP]) |=> (grant == (ONE << ($past(slot) ^ FLIP))));
endmodule

bind hub_pair_arbiter hub_pair_arbiter_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk   (clk),
    .rst   (rst),
    .grant (grant_o),
    .idx   (idx_o),
    .slot  (slot_q),
    .elig  (run_i & hub_en_i & want_i)
);

// File: tb/hub_pair_arbiter_tb_top.sv
module hub_pair_arbiter_tb_top;
    localparam int N = 16;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] top_core = 4'd15;
    logic [N-1:0] run = '0;
    logic [N-1:0] hub_en = '0;
    logic [N-1:0] want = '0;
    logic [N-1:0] grant_o;
    logic [W-1:0] idx_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hub_pair_arbiter dut_i (
        .clk(clk), .rst(rst), .scan_mode_i(mode), .top_core_i(top_core),
        .run_i(run), .hub_en_i(hub_en), .want_i(want),
        .grant_o(grant_o), .idx_o(idx_o)
    );

    // reference model state
    int           m_slot;
    int           m_top;
    logic [N-1:0] m_grant;
    int           m_idx;
    string        m_case;
    string        m_mtag;

    function automatic int model_next(int md, int s, int t, logic [N-1:0] part);
        int lo;
        lo = -1;
        if (md == 1) return (s >= t) ? 0 : s + 1;
        if (md == 2) begin
            for (int i = 0; i < N; i++) begin
                if (part[i] && i > s) return i;
            end
            for (int i = N - 1; i >= 0; i--) begin
                if (part[i]) lo = i;
            end
            return (lo < 0) ? 0 : lo;
        end
        return (s == N - 1) ? 0 : s + 1;
    endfunction

    always @(posedge clk) begin
        logic [N-1:0] el;
        int pr;
        int nx;
        if (rst) begin
            m_slot = 0; m_top = N - 1; m_grant = '0; m_idx = 0;
            m_case = "R1"; m_mtag = "R1";
        end else begin
            el = run & hub_en & want;
            pr = m_slot ^ 8;
            if (el[m_slot]) begin
                m_grant = N'(1) << m_slot; m_idx = m_slot; m_case = "R2";
            end else if (el[pr]) begin
                m_grant = N'(1) << pr; m_idx = pr; m_case = "R3";
            end else begin
                m_grant = '0; m_idx = 0; m_case = "R4";
            end
            m_mtag = (mode == 2'd1) ? "R7" : (mode == 2'd2) ? "R8" : "R6";
            nx = model_next(int'(mode), m_slot, m_top, run & hub_en);
            if (nx <= m_slot) m_top = int'(top_core);
            m_slot = nx;
        end
    end

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic step_check();
        @(negedge clk);
        check(grant_o == m_grant, m_case, "grant", int'(grant_o), int'(m_grant));
        check(int'(idx_o) == m_idx, m_mtag, "idx", int'(idx_o), m_idx);
        check($countones(grant_o) <= 1, "R5", "grant bits", $countones(grant_o), 1);
        check(grant_o == '0 || grant_o[idx_o], "R5", "idx vs grant", int'(idx_o), m_idx);
    endtask

    task automatic rand_pairs();
        want = N'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(grant_o == '0, "R1", "grant in reset", int'(grant_o), 0);
        check(idx_o == '0, "R1", "idx in reset", int'(idx_o), 0);
        run = '1; hub_en = '1; want = '0;
        rst = 1'b0;
        repeat (3) step_check();
        // R9: input change between edges leaves outputs unchanged
        want = '1;
        #1;
        check(grant_o == '0, "R9", "grant before edge", int'(grant_o), 0);
        repeat (20) step_check();

        // full scan with random wants (R6, R2..R4)
        for (int k = 0; k < 300; k++) begin
            mode = ($urandom % 2) ? 2'd0 : 2'd3;
            rand_pairs();
            step_check();
        end

        // early wrap: top set low, then moved mid rotation (R7)
        mode = 2'd1; want = '1; top_core = 4'd3;
        repeat (40) step_check();
        top_core = 4'd9;
        repeat (2) step_check();
        top_core = 4'd1;
        repeat (30) step_check();
        top_core = 4'd0;
        repeat (10) step_check();
        for (int k = 0; k < 300; k++) begin
            if ($urandom % 8 == 0) top_core = W'($urandom);
            rand_pairs();
            step_check();
        end

        // active-only scanning (R8), including empty set
        mode = 2'd2; want = '1;
        run = '0; hub_en = '1;
        repeat (5) step_check();
        run = 16'h0105; hub_en = 16'h0107;
        repeat (12) step_check();
        run = 16'h8000;
        repeat (5) step_check();
        for (int k = 0; k < 400; k++) begin
            if ($urandom % 6 == 0) begin
                run = N'($urandom); hub_en = N'($urandom);
            end
            rand_pairs();
            step_check();
        end

        // everything random, including mode switches mid-rotation
        for (int k = 0; k < 600; k++) begin
            if ($urandom % 10 == 0) mode = 2'($urandom);
            if ($urandom % 10 == 0) top_core = W'($urandom);
            run = N'($urandom) | N'($urandom);
            hub_en = N'($urandom) | N'($urandom);
            rand_pairs();
            step_check();
        end

        // reset mid-run (R1)
        rst = 1'b1;
        step_check();
        check(grant_o == '0, "R1", "grant after reset", int'(grant_o), 0);
        rst = 1'b0; mode = 2'd0; run = '1; hub_en = '1; want = '1;
        step_check();
        check(idx_o == '0, "R1", "first slot after reset", int'(idx_o), 0);
        step_check();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule